// File: doc/BRIEF.md
# Moore Serial Pattern Detector

This block is a clocked Moore state machine that recognises the five-bit serial pattern 1, 0, 0, 1, 0 as it is entered by hand, one bit at a time. An operator sets a data level and presses a step button. The button is synchronised and debounced on the system clock. Each accepted press becomes a single-cycle step enable that samples the data bit and moves the machine.

Six progress lights show how much of the pattern has been matched so far. Exactly one light is on at any time. A separate found output comes on together with the last light once the whole pattern has been seen. After a completed match, the next step returns the machine to the idle state, so a completed match never counts toward the next one. All logic runs on the single system clock, and no clock is gated.

Top module: `serial_pattern_finder`

## Requirements
- R1: Stepping in the bits 1, 0, 0, 1, 0 from idle raises `found` after the fifth accepted step.
- R2: The matched prefix length selects the lit progress bit. `stage_led[0]` means nothing is matched. Bits 1, 2, 3 and 4 mean the prefixes "1", "10", "100" and "1001". Bit 5 means the full pattern.
- R3: Exactly one bit of `stage_led` is high in every cycle.
- R4: `found` is high exactly when `stage_led[5]` is high.
- R5: A mismatching bit keeps the longest matching suffix. Idle stays idle on 0. Prefix "1" stays on 1. Prefix "10" goes to "1" on 1. Prefix "100" goes to idle on 0. Prefix "1001" goes to "1" on 1.
- R6: From the full-match stage, the next accepted step goes to idle, whatever the data bit.
- R7: Outputs change only after an accepted step. Toggling `bit_in` with no press has no effect on `stage_led` or `found`.
- R8: A high `rst` at a clock edge puts the machine in idle, with `stage_led` = 6'b000001 and `found` low.
- R9: A press is accepted only after the synchronised button has held a new level for `STABLE_CYCLES` consecutive clocks. A shorter pulse produces no step.
- R10: Each accepted press gives exactly one step, however long the button is held. The button must be released (stably) before another press counts.
- R11: Reset also clears the debouncer, so no step occurs in the cycle after `rst` falls, even if the button is held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Data bit sampled on an accepted step (1 = one, 0 = zero) |
| step_btn | input | 1 | Raw, asynchronous step push button, high when pressed |
| stage_led | output | 6 | One-hot progress lights, bit i = i pattern bits matched |
| found | output | 1 | High while the full pattern has been matched |

## Verification
A wrong state register shows at the ports in the same cycle, because the lights decode the state directly. A state that falls outside the six legal codes leaves no light on. A wrong transition shows one step later, as the wrong light after a press. A debouncer fault shows as a missing advance or an extra advance. The bench therefore compares the lit stage after every press, including long holds and short glitches, against the prefix length that it computes from the bits it entered.

// File: rtl/serial_pattern_finder.sv
module serial_pattern_finder #(
  parameter int STABLE_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  input  logic       step_btn,
  output logic [5:0] stage_led,
  output logic       found
);

  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P1   = 3'd1,
    ST_P10  = 3'd2,
    ST_P100 = 3'd3,
    ST_P1001 = 3'd4,
    ST_FULL = 3'd5
  } stage_t;

  logic          btn_m, btn_s, btn_level;
  logic [CW-1:0] dwell;
  logic          step_pulse;
  stage_t        stage, stage_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_m      <= 1'b0;
      btn_s      <= 1'b0;
      btn_level  <= 1'b0;
      dwell      <= '0;
      step_pulse <= 1'b0;
    end else begin
      btn_m      <= step_btn;
      btn_s      <= btn_m;
      step_pulse <= 1'b0;
      if (btn_s == btn_level) begin
        dwell <= '0;
      end else if (dwell == CNT_LAST) begin
        dwell      <= '0;
        btn_level  <= btn_s;
        step_pulse <= btn_s;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end

  always_comb begin
    stage_nx = stage;
    unique case (stage)
      ST_IDLE:  stage_nx = bit_in ? ST_P1    : ST_IDLE;
      ST_P1:    stage_nx = bit_in ? ST_P1    : ST_P10;
      ST_P10:   stage_nx = bit_in ? ST_P1    : ST_P100;
      ST_P100:  stage_nx = bit_in ? ST_P1001 : ST_IDLE;
      ST_P1001: stage_nx = bit_in ? ST_P1    : ST_FULL;
      ST_FULL:  stage_nx = ST_IDLE;
      default:  stage_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             stage <= ST_IDLE;
    else if (step_pulse) stage <= stage_nx;
  end

  assign stage_led = 6'b000001 << stage;
  assign found     = (stage == ST_FULL);

endmodule

// File: rtl/pattern_finder_checks.sv
module pattern_finder_checks (
  input logic       clk,
  input logic       rst,
  input logic       step_pulse,
  input logic [5:0] stage_led,
  input logic       found
);

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(stage_led) == 1);

  assert_found_tracks_last_R4: assert property (@(posedge clk) disable iff (rst)
    found == stage_led[5]);

  assert_hold_without_step_R7: assert property (@(posedge clk) disable iff (rst)
    !step_pulse |=> $stable(stage_led));

  assert_full_returns_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && found) |=> stage_led == 6'b000001);

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (stage_led == 6'b000001 && !found));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

  assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !step_pulse);

endmodule

bind serial_pattern_finder pattern_finder_checks u_chk (
  .clk(clk),
  .rst(rst),
  .step_pulse(step_pulse),
  .stage_led(stage_led),
  .found(found)
);

// File: tb/serial_pattern_finder_tb.sv
module serial_pattern_finder_tb;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       step_btn = 1'b0;
  logic [5:0] stage_led;
  logic       found;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  serial_pattern_finder #(.STABLE_CYCLES(N)) u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .step_btn(step_btn),
    .stage_led(stage_led), .found(found)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_stage(input int idx, input string req);
    logic [5:0] exp_led;
    logic       exp_found;
    exp_led   = 6'b000001 << idx;
    exp_found = (idx == 5);
    vectors++;
    if (stage_led !== exp_led || found !== exp_found) begin
      misses++;
      $display("FAIL %s: led=%b found=%b expected led=%b found=%b",
               req, stage_led, found, exp_led, exp_found);
    end
  endtask

  task automatic press(input logic b);
    @(negedge clk);
    bit_in   = b;
    step_btn = 1'b1;
    wait_cyc(N + 6);
    step_btn = 1'b0;
    wait_cyc(N + 6);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_stage(0, "R8 reset state");
  endtask

  task automatic t_full_pattern();
    do_reset();
    press(1'b1); expect_stage(1, "R2 after 1");
    press(1'b0); expect_stage(2, "R2 after 10");
    press(1'b0); expect_stage(3, "R2 after 100");
    press(1'b1); expect_stage(4, "R2 after 1001");
    press(1'b0); expect_stage(5, "R1 R4 full match");
    press(1'b1); expect_stage(0, "R6 full then 1 goes idle");
    press(1'b1); press(1'b0); press(1'b0); press(1'b1); press(1'b0);
    expect_stage(5, "R1 second match");
    press(1'b0); expect_stage(0, "R6 full then 0 goes idle");
  endtask

  task automatic t_mismatch();
    do_reset();
    press(1'b0); expect_stage(0, "R5 idle on 0");
    press(1'b1); press(1'b1); expect_stage(1, "R5 prefix 1 on 1");
    press(1'b0); press(1'b1); expect_stage(1, "R5 prefix 10 on 1");
    press(1'b0); press(1'b0); press(1'b0); expect_stage(0, "R5 prefix 100 on 0");
    press(1'b1); press(1'b0); press(1'b0); press(1'b1); press(1'b1);
    expect_stage(1, "R5 prefix 1001 on 1");
  endtask

  task automatic t_data_ignored();
    do_reset();
    press(1'b1); press(1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bit_in = ~bit_in;
    end
    wait_cyc(4);
    expect_stage(2, "R7 data toggles without press");
  endtask

  task automatic t_glitch();
    do_reset();
    press(1'b1);
    @(negedge clk);
    bit_in   = 1'b0;
    step_btn = 1'b1;
    wait_cyc(N - 3);
    step_btn = 1'b0;
    wait_cyc(3 * N);
    expect_stage(1, "R9 short pulse rejected");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      step_btn = ~step_btn;
    end
    step_btn = 1'b0;
    wait_cyc(3 * N);
    expect_stage(1, "R9 bouncing rejected");
  endtask

  task automatic t_hold();
    do_reset();
    @(negedge clk);
    bit_in   = 1'b1;
    step_btn = 1'b1;
    wait_cyc(6 * N);
    expect_stage(1, "R10 long hold gives one step");
    bit_in = 1'b0;
    wait_cyc(4 * N);
    expect_stage(1, "R10 still one step while held");
    step_btn = 1'b0;
    wait_cyc(2 * N);
    expect_stage(1, "R10 release gives no step");
    press(1'b0);
    expect_stage(2, "R10 new press after release");
  endtask

  task automatic t_reset_with_button();
    do_reset();
    press(1'b1); press(1'b0); press(1'b0);
    expect_stage(3, "R2 prefix 100 before reset");
    @(negedge clk);
    bit_in   = 1'b1;
    step_btn = 1'b1;
    rst      = 1'b1;
    wait_cyc(3);
    expect_stage(0, "R8 reset mid pattern");
    rst = 1'b0;
    wait_cyc(2);
    expect_stage(0, "R11 no step after reset release");
    wait_cyc(N + 6);
    expect_stage(1, "R11 held button accepted after full dwell");
    step_btn = 1'b0;
    wait_cyc(N + 6);
  endtask

  initial begin
    #(200000 * 10);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    t_reset_state();
    t_full_pattern();
    t_mismatch();
    t_data_ignored();
    t_glitch();
    t_hold();
    t_reset_with_button();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule